// File: doc/BRIEF.md
# Gated Oscillator Frequency Meter

The meter measures the frequency of one of several oscillator inputs by counting rising edges of the selected input, after an optional pre-divider, during a fixed gating window timed by a reference clock. With the default window of 977 reference cycles at 26 MHz, one count stands for roughly 26×1024 Hz.

Software programs a configuration word with a mode, a source and a divisor. It sets the enable bit, then writes the self-clearing run bit. The edge counter runs in the measured clock's own domain. At the end of the window the count is handed back to the reference domain through a toggle handshake. The run bit drops in the same cycle that the result register is loaded. Clearing enable aborts a run.

Top module: `fm_meter`

## Requirements
- R1: After reset, the configuration word, the control word (enable bit 0, run bit 1) and the result (address 2) all read as zero.
- R2: The configuration word (address 0) holds the mode in bits [1:0], the source code in bits [21:16] and the divisor code in bits [31:24]. All other bits read as zero.
- R3: A control write (address 1) with bit 0 and bit 1 both set starts a run only if all of these hold: enable was already set, the mode is 00, the source code is below NUM_SRC, and no run is in progress. Otherwise the run request is ignored and run reads zero. The enable bit still takes bit 0.
- R4: A run stays set for at least WIN_CYC reference cycles. It then clears by itself without further writes.
- R5: The result lies between floor((E-2)/(D+1)) and floor((E+1)/(D+1)). Here E is the number of periods of the selected source that fit into WIN_CYC reference cycles, and D is the divisor code.
- R6: Divisor code 0 divides by one, and code 1 halves the count.
- R7: The count saturates at 2^CNT_W-1 and does not wrap.
- R8: A control write with bit 0 clear stops a run in progress. Run reads zero after that write, and the result keeps its previous value.
- R9: Writes to the configuration word are ignored while a run is in progress.
- R10: The result changes only when a run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_i | input | NUM_SRC | Oscillator inputs under measurement |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 config, 1 control |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address: 0 config, 1 control, 2 result |
| rd_data_o | output | 32 | Read data for rd_addr_i, combinational |

## Verification
The bench builds the meter with three sources, a 40-cycle window and a 6-bit counter. These values keep each run short enough for many random source and divisor mixes. The fastest source overflows the 6-bit counter at divisor 0, so saturation is reached, while the slower sources at larger divisors give small counts where the divide-by-one and halving ratios are visible.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_GATE, ST_WAIT} fm_state_e;

  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_CTL = 2'd1;
  localparam logic [1:0] ADDR_RES = 2'd2;

  localparam logic [1:0] MODE_MEASURE = 2'b00;

  localparam int CTL_EN  = 0;
  localparam int CTL_RUN = 1;
  localparam int SRC_LSB = 16;
  localparam int DIV_LSB = 24;
endpackage

// File: rtl/fm_bit_sync.sv
module fm_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/fm_osc_count.sv
module fm_osc_count #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_tgl_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gate_s, gate_d;
  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tgl_q;

  fm_bit_sync #(.STAGES(2)) u_gate_sync (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_s)
  );

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      tgl_q  <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (gate_s && !gate_d) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (gate_s && gate_d) begin
        if (pre_q == div_i) begin
          pre_q <= '0;
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
      // window closed: count is frozen, hand it over
      if (!gate_s && gate_d) tgl_q <= ~tgl_q;
    end
  end

  assign cnt_o      = cnt_q;
  assign done_tgl_o = tgl_q;

  // R7
  cnt_saturate_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && gate_s && gate_d) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int WIN_CYC = 977,
  parameter int CNT_W   = 16,
  parameter int SRC_W   = 6,
  parameter int DIV_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [31:0]      rd_data_o,
  output logic             gate_o,
  output logic [SRC_W-1:0] src_o,
  output logic [DIV_W-1:0] div_o,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             done_tgl_i
);
  localparam int               WIN_W    = $clog2(WIN_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [SRC_W-1:0] SRC_LIM  = SRC_W'(NUM_SRC);

  fm_state_e        state_q;
  logic [1:0]       mode_q;
  logic [SRC_W-1:0] src_q;
  logic [DIV_W-1:0] div_q;
  logic             en_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] res_q;
  logic             tgl_s, tgl_d, done_evt;
  logic             busy, wr_cfg, wr_ctl, start_ok;

  fm_bit_sync #(.STAGES(2)) u_tgl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(done_tgl_i), .q_o(tgl_s)
  );

  assign busy     = (state_q != ST_IDLE);
  assign done_evt = tgl_s ^ tgl_d;
  assign wr_cfg   = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign wr_ctl   = wr_en_i && (wr_addr_i == ADDR_CTL);
  assign start_ok = wr_ctl && wr_data_i[CTL_EN] && wr_data_i[CTL_RUN] && en_q &&
                    (mode_q == MODE_MEASURE) && (src_q < SRC_LIM) && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      src_q   <= '0;
      div_q   <= '0;
      en_q    <= 1'b0;
      win_q   <= '0;
      res_q   <= '0;
      tgl_d   <= 1'b0;
    end else begin
      tgl_d <= tgl_s;
      if (wr_cfg && !busy) begin
        mode_q <= wr_data_i[1:0];
        src_q  <= wr_data_i[SRC_LSB +: SRC_W];
        div_q  <= wr_data_i[DIV_LSB +: DIV_W];
      end
      if (wr_ctl) en_q <= wr_data_i[CTL_EN];
      if (wr_ctl && !wr_data_i[CTL_EN]) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_ok) begin
            state_q <= ST_GATE;
            win_q   <= '0;
          end
          ST_GATE: if (win_q == WIN_LAST) state_q <= ST_WAIT;
                   else win_q <= win_q + 1'b1;
          ST_WAIT: if (done_evt) begin
            res_q   <= cnt_i;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_CFG: begin
        rd_data_o[1:0]                = mode_q;
        rd_data_o[SRC_LSB +: SRC_W]   = src_q;
        rd_data_o[DIV_LSB +: DIV_W]   = div_q;
      end
      ADDR_CTL: begin
        rd_data_o[CTL_EN]  = en_q;
        rd_data_o[CTL_RUN] = busy;
      end
      ADDR_RES: rd_data_o[CNT_W-1:0] = res_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign gate_o = (state_q == ST_GATE);
  assign src_o  = src_q;
  assign div_o  = div_q;

  // R3
  run_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(en_q));
  // R4
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q < WIN_W'(WIN_CYC));
  // R8
  abort_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && !wr_data_i[CTL_EN]) |=> !busy);
  // R9
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(src_q) && $stable(div_q) && $stable(mode_q)));
  // R10
  res_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_q != $past(res_q)) |-> ($past(state_q) == ST_WAIT));
endmodule

// File: rtl/fm_meter.sv
module fm_meter #(
  parameter int NUM_SRC = 4,
  parameter int WIN_CYC = 977,
  parameter int CNT_W   = 16,
  parameter int SRC_W   = 6,
  parameter int DIV_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] osc_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [31:0]        wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [31:0]        rd_data_o
);
  logic             gate, done_tgl, meas_clk;
  logic [SRC_W-1:0] src;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt;

  fm_ctrl #(
    .NUM_SRC(NUM_SRC), .WIN_CYC(WIN_CYC), .CNT_W(CNT_W), .SRC_W(SRC_W), .DIV_W(DIV_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .gate_o(gate), .src_o(src), .div_o(div),
    .cnt_i(cnt), .done_tgl_i(done_tgl)
  );

  // source changes only while idle, so the mux never switches mid-window
  always_comb begin
    meas_clk = osc_i[0];
    for (int i = 1; i < NUM_SRC; i++)
      if (src == SRC_W'(i)) meas_clk = osc_i[i];
  end

  fm_osc_count #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cnt (
    .osc_clk_i(meas_clk), .rst_ni(rst_ni), .gate_i(gate),
    .div_i(div), .cnt_o(cnt), .done_tgl_o(done_tgl)
  );
endmodule

// File: tb/sim_fm_meter.sv
`timescale 1ns/100ps
module sim_fm_meter;
  localparam int NS = 3, WIN = 40, CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 0, rst_n = 0;
  logic [NS-1:0] osc = '0;
  logic          wr_en = 0;
  logic [1:0]    wr_addr = 0, rd_addr = 0;
  logic [31:0]   wr_data = 0;
  logic [31:0]   rd_data;
  int            n_chk = 0, n_fail = 0;

  fm_meter #(.NUM_SRC(NS), .WIN_CYC(WIN), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_i(osc),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always #2 clk = ~clk;
  always #5 osc[0] = ~osc[0];
  always #3 osc[1] = ~osc[1];
  always #1 osc[2] = ~osc[2];

  function automatic int period(int s);
    return (s == 0) ? 10 : (s == 1) ? 6 : 2;
  endfunction
  function automatic int lo_bound(int s, int d);
    int e = WIN * 4 / period(s);
    int v = ((e >= 2) ? e - 2 : 0) / (d + 1);
    return (v > CMAX) ? CMAX : v;
  endfunction
  function automatic int hi_bound(int s, int d);
    int v = (WIN * 4 / period(s) + 1) / (d + 1);
    return (v > CMAX) ? CMAX : v;
  endfunction
  function automatic logic [31:0] cfg_word(int m, int s, int d);
    return {8'(d), 2'b0, 6'(s), 14'b0, 2'(m)};
  endfunction

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd(2'd1, v);
    while (v[1] && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      rd(2'd1, v);
    end
  endtask

  task automatic measure(input int s, input int d, input string req);
    logic [31:0] v;
    int cyc;
    wr(2'd0, cfg_word(0, s, d));
    wr(2'd1, 32'h1);
    wr(2'd1, 32'h3);
    rd(2'd1, v);
    chk(v[1] == 1'b1, "R4 run set", int'(v[1]), 1);
    wait_idle(cyc);
    chk(cyc + 1 >= WIN && cyc < 2000, "R4 self-clear", cyc + 1, WIN);
    rd(2'd2, v);
    chk(int'(v) >= lo_bound(s, d) && int'(v) <= hi_bound(s, d), req, int'(v), lo_bound(s, d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, res;
    int cyc;
    int unsigned seed = $urandom(11);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1
    rd(2'd0, v); chk(v == 0, "R1 cfg", int'(v), 0);
    rd(2'd1, v); chk(v == 0, "R1 ctl", int'(v), 0);
    rd(2'd2, v); chk(v == 0, "R1 res", int'(v), 0);

    // R2
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk(v == 32'hFF3F_0003, "R2 mask", int'(v), int'(32'hFF3F_0003));
    wr(2'd0, cfg_word(0, 2, 5));
    rd(2'd0, v); chk(v == cfg_word(0, 2, 5), "R2 fields", int'(v), int'(cfg_word(0, 2, 5)));

    // R3: run with enable written in same cycle
    wr(2'd0, cfg_word(0, 0, 0));
    wr(2'd1, 32'h3);
    rd(2'd1, v); chk(v == 32'h1, "R3 no prior enable", int'(v), 1);
    wr(2'd1, 32'h0);
    wr(2'd0, cfg_word(1, 0, 0));
    wr(2'd1, 32'h1); wr(2'd1, 32'h3);
    rd(2'd1, v); chk(v[1] == 0, "R3 mode", int'(v[1]), 0);
    wr(2'd0, cfg_word(0, 3, 0));
    wr(2'd1, 32'h3);
    rd(2'd1, v); chk(v[1] == 0, "R3 src range", int'(v[1]), 0);
    repeat (120) @(negedge clk);
    rd(2'd2, v); chk(v == 0, "R3 res untouched", int'(v), 0);

    // R6 and R7
    measure(0, 0, "R6 div0");
    measure(0, 1, "R6 div1");
    measure(2, 0, "R7 saturate");
    rd(2'd2, v); chk(v == CMAX, "R7 max", int'(v), CMAX);

    // R9
    wr(2'd0, cfg_word(0, 1, 2));
    wr(2'd1, 32'h3);
    wr(2'd0, cfg_word(0, 2, 7));
    rd(2'd0, v); chk(v == cfg_word(0, 1, 2), "R9 cfg frozen", int'(v), int'(cfg_word(0, 1, 2)));
    wait_idle(cyc);
    rd(2'd2, v);
    chk(int'(v) >= lo_bound(1, 2) && int'(v) <= hi_bound(1, 2), "R9 used old cfg", int'(v), lo_bound(1, 2));

    // R8 and R10
    rd(2'd2, res);
    wr(2'd0, cfg_word(0, 0, 3));
    wr(2'd1, 32'h3);
    repeat (5) @(negedge clk);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk(v == 0, "R8 abort", int'(v), 0);
    repeat (120) @(negedge clk);
    rd(2'd2, v); chk(v == res, "R10 res kept", int'(v), int'(res));

    // R5 random
    for (int i = 0; i < 16; i++) begin
      int s = int'($urandom % NS);
      int d = int'($urandom % 8);
      measure(s, d, "R5 count");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule